// File: doc/BRIEF.md
# Bus Error Interrupt Control Register

This block is a single 32-bit control and status register that gathers four bus error events into one interrupt line. The four events are a received system error, a received parity error, a master abort and a target abort. Each event sets a sticky flag that software can read. A per-source mask bit stops that flag from reaching the interrupt output. A separate per-source clear bit, which can only be written, drops the flag.

The register sits on a simple slave port. The port has a byte address, a write enable, 32-bit write data and combinational 32-bit read data, with no byte lanes. The register answers only at its fixed offset. Each source is tracked by a two-state flag machine. The state `FLAG_IDLE` moves to `FLAG_PEND` through transition `EV_SET` when the event input is high. `FLAG_PEND` moves back to `FLAG_IDLE` through transition `CLR_DROP` when a clear is written and no event arrives in the same cycle. Otherwise a pending flag stays in `FLAG_PEND` through transition `HOLD`. The interrupt output is a registered OR over all unmasked pending flags.

Top module: `bus_err_irq_ctl`

## Requirements
- R1: After reset, every status flag is 0 and every mask bit is 1. The register reads 0x00000F00 and `irq_o` is 0.
- R2: A high `ev_i[i]` at a clock edge sets status bit i, which is readable right after that edge. The bit order is: bit 0 target abort, bit 1 master abort, bit 2 parity error received, bit 3 system error received.
- R3: A status bit stays 1 after its event input goes low. It stays 1 until a clear for that source is written.
- R4: Writing 1 to clear bit 16+i (same source order) at the register offset drops status bit i at that edge. Writing 0 to a clear bit leaves the status unchanged.
- R5: If an event and a clear for the same source fall in the same cycle, the event wins and the status bit stays 1.
- R6: Mask bits 11:8 (same source order) are read/write at the register offset, where 1 means masked. A masked source's status bit can still be read.
- R7: `irq_o` is registered. One cycle after any change of status or mask, it equals the OR over i of (status[i] AND NOT mask[i]).
- R8: The clear bits and all unused bits read as 0. Writes to the unused bits and to the read-only status bits have no effect.
- R9: The register is decoded at byte offset 0x18 only. Any other address reads 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_i | input | 4 | Error event pulses: bit 0 target abort, 1 master abort, 2 parity error, 3 system error |
| bus_addr | input | 8 | Byte address of the access |
| bus_we | input | 1 | Write enable, one write per high cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined error interrupt, registered |

## Verification
The bench builds the block with its default parameters: four sources, an 8-bit address and the register at 0x18. With these defaults every field position and the sole decoded offset are the ones named in the requirements. With four sources, a single write can clear several flags while another source has an event in the same cycle. A non-matching address such as 0x1C sits one word away, so a decode that ignores the low address bits would show up.

// File: rtl/berr_pkg.sv
package berr_pkg;
    localparam int NUM_SRC  = 4;
    localparam int DATA_W   = 32;
    localparam int STAT_LSB = 0;
    localparam int MASK_LSB = 8;
    localparam int CLR_LSB  = 16;

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_PEND = 1'b1
    } flag_state_t;
endpackage

// File: rtl/berr_flag_cell.sv
module berr_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic event_i,
    input  logic clear_i,
    input  logic mask_wr_i,
    input  logic mask_d_i,
    output logic flag_o,
    output logic mask_o
);
    import berr_pkg::*;

    flag_state_t state_q, state_d;
    logic        mask_q;

    // next-state: EV_SET, CLR_DROP, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: if (event_i) state_d = FLAG_PEND;
            FLAG_PEND: if (clear_i && !event_i) state_d = FLAG_IDLE;
            default:   state_d = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         mask_q <= 1'b1;
        else if (mask_wr_i) mask_q <= mask_d_i;
    end

    always_comb begin
        flag_o = (state_q == FLAG_PEND);
        mask_o = mask_q;
    end
endmodule

// File: rtl/berr_reg_decode.sv
module berr_reg_decode #(
    parameter int          NUM_SRC    = berr_pkg::NUM_SRC,
    parameter int          ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h18
) (
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_we,
    input  logic [berr_pkg::DATA_W-1:0] bus_wdata,
    input  logic [NUM_SRC-1:0]          flags,
    input  logic [NUM_SRC-1:0]          masks,
    output logic [NUM_SRC-1:0]          clr_vec,
    output logic                        mask_wr,
    output logic [NUM_SRC-1:0]          mask_d,
    output logic [berr_pkg::DATA_W-1:0] bus_rdata
);
    import berr_pkg::*;

    logic hit;

    always_comb begin
        hit     = (bus_addr == REG_OFFSET);
        mask_wr = hit && bus_we;
        mask_d  = bus_wdata[MASK_LSB +: NUM_SRC];
        clr_vec = mask_wr ? bus_wdata[CLR_LSB +: NUM_SRC] : '0;
        bus_rdata = '0;
        if (hit) begin
            bus_rdata[STAT_LSB +: NUM_SRC] = flags;
            bus_rdata[MASK_LSB +: NUM_SRC] = masks;
        end
    end
endmodule

// File: rtl/berr_irq_merge.sv
module berr_irq_merge #(
    parameter int NUM_SRC = berr_pkg::NUM_SRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] flags,
    input  logic [NUM_SRC-1:0] masks,
    output logic               irq_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |(flags & ~masks);
    end
endmodule

// File: rtl/bus_err_irq_ctl.sv
module bus_err_irq_ctl #(
    parameter int                NUM_SRC    = berr_pkg::NUM_SRC,
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h18
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SRC-1:0]          ev_i,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_we,
    input  logic [berr_pkg::DATA_W-1:0] bus_wdata,
    output logic [berr_pkg::DATA_W-1:0] bus_rdata,
    output logic                        irq_o
);
    logic [NUM_SRC-1:0] flag_vec;
    logic [NUM_SRC-1:0] mask_vec;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] mask_d;
    logic               mask_wr;

    berr_reg_decode #(
        .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)
    ) u_decode (
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .flags    (flag_vec),
        .masks    (mask_vec),
        .clr_vec  (clr_vec),
        .mask_wr  (mask_wr),
        .mask_d   (mask_d),
        .bus_rdata(bus_rdata)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        berr_flag_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .event_i  (ev_i[i]),
            .clear_i  (clr_vec[i]),
            .mask_wr_i(mask_wr),
            .mask_d_i (mask_d[i]),
            .flag_o   (flag_vec[i]),
            .mask_o   (mask_vec[i])
        );
    end

    berr_irq_merge #(.NUM_SRC(NUM_SRC)) u_merge (
        .clk  (clk),
        .rst_n(rst_n),
        .flags(flag_vec),
        .masks(mask_vec),
        .irq_o(irq_o)
    );
endmodule

// File: rtl/berr_irq_ctl_chk.sv
module berr_irq_ctl_chk #(
    parameter int                NUM_SRC    = 4,
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h18
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] ev_i,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_we,
    input logic [31:0]        bus_wdata,
    input logic [31:0]        bus_rdata,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] flags,
    input logic [NUM_SRC-1:0] masks
);
    logic               wr_hit;
    logic [NUM_SRC-1:0] clr_req;
    always_comb begin
        wr_hit  = bus_we && (bus_addr == REG_OFFSET);
        clr_req = wr_hit ? bus_wdata[16 +: NUM_SRC] : '0;
    end

    p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i != '0) |=> ((flags & $past(ev_i)) == $past(ev_i)));

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & $past(flags & ~clr_req)) == $past(flags & ~clr_req)));

    p_clear_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_req & ~ev_i) != '0) |=> ((flags & $past(clr_req & ~ev_i)) == '0));

    p_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_req & ev_i) != '0) |=> ((flags & $past(clr_req & ev_i)) == $past(clr_req & ev_i)));

    p_mask_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (masks == $past(bus_wdata[8 +: NUM_SRC])));

    p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(masks));

    p_irq_merge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == |$past(flags & ~masks)));

    p_offset_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != REG_OFFSET) |-> (bus_rdata == 32'h0));
endmodule

bind bus_err_irq_ctl berr_irq_ctl_chk #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_i     (ev_i),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_o    (irq_o),
    .flags    (flag_vec),
    .masks    (mask_vec)
);

// File: tb/bus_err_irq_ctl_bench.sv
module bus_err_irq_ctl_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] OFS = 8'h18;

    typedef struct packed {
        logic [3:0]  ev;
        logic        we;
        logic [7:0]  addr;
        logic [31:0] wd;
        logic [31:0] exp_rd;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{4'h1, 1'b0, 8'h18, 32'h0000_0000, 32'h0000_0F01, 1'b0}, // R2 target abort, masked
        '{4'h0, 1'b1, 8'h18, 32'h0000_0E00, 32'h0000_0E01, 1'b1}, // R6 unmask bit0
        '{4'h0, 1'b0, 8'h18, 32'h0000_0000, 32'h0000_0E01, 1'b1}, // R3 sticky
        '{4'h0, 1'b1, 8'h18, 32'h0001_0E00, 32'h0000_0E00, 1'b0}, // R4 clear bit0
        '{4'hC, 1'b0, 8'h18, 32'h0000_0000, 32'h0000_0E0C, 1'b0}, // R2 sys+parity, masked
        '{4'h0, 1'b1, 8'h18, 32'h0000_0000, 32'h0000_000C, 1'b1}, // R6 unmask all
        '{4'h4, 1'b1, 8'h18, 32'h0004_0000, 32'h0000_000C, 1'b1}, // R5 event beats clear
        '{4'h0, 1'b1, 8'h18, 32'hFFF0_F0F0, 32'h0000_000C, 1'b1}, // R8 unused/status writes
        '{4'h0, 1'b1, 8'h1C, 32'h000F_0F00, 32'h0000_000C, 1'b1}, // R9 other offset write
        '{4'h0, 1'b1, 8'h18, 32'h0008_0F00, 32'h0000_0F04, 1'b0}, // R4 clear bit3, mask all
        '{4'h2, 1'b1, 8'h18, 32'h000F_0D00, 32'h0000_0D02, 1'b1}, // R5 clear all, bit1 event
        '{4'h0, 1'b1, 8'h18, 32'h0002_0D00, 32'h0000_0D00, 1'b0}  // R4 clear bit1
    };
    string VTAG [NV] = '{"R2","R6","R3","R4","R2","R6","R5","R8","R9","R4","R5","R4"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ev_i = '0;
    logic [7:0]  bus_addr = OFS;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_err_irq_ctl u_bus_err_irq_ctl (
        .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic idle_read(input logic [7:0] a);
        ev_i = '0; bus_we = 1'b0; bus_wdata = '0; bus_addr = a;
    endtask

    // apply one vector, then read back and observe irq one cycle later
    task automatic apply(input vec_t v, input string tag);
        @(negedge clk);
        ev_i = v.ev; bus_we = v.we; bus_addr = v.addr; bus_wdata = v.wd;
        @(negedge clk);
        idle_read(OFS);
        #1 check(tag, bus_rdata, v.exp_rd);
        @(negedge clk);
        check({tag, "_irq"}, {31'b0, irq_o}, {31'b0, v.exp_irq});
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 check("R1_rd_in_reset", bus_rdata, 32'h0000_0F00);
        check("R1_irq_in_reset", {31'b0, irq_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        #1 check("R1_rd", bus_rdata, 32'h0000_0F00);
        check("R1_irq", {31'b0, irq_o}, 32'h0);

        for (int k = 0; k < NV; k++) apply(VECS[k], VTAG[k]);

        // R9: pending system error, read at a neighbouring offset gives 0
        @(negedge clk);
        ev_i = 4'h8;
        @(negedge clk);
        idle_read(8'h1C);
        #1 check("R9_other_read", bus_rdata, 32'h0);
        idle_read(8'h18);
        #1 check("R3_after_other_read", bus_rdata, 32'h0000_0D08);

        // R1: reset mid-run restores defaults
        @(negedge clk);
        rst_n = 1'b0;
        #1 check("R1_rerst_rd", bus_rdata, 32'h0000_0F00);
        check("R1_rerst_irq", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule